// File: doc/BRIEF.md
# SPI Byte Transfer Engine (master or slave)

This block moves one byte at a time over a four-wire SPI link. A single 8-bit control word sets it up. The word enables the engine, picks master or slave operation, picks clock polarity, clock phase and bit order, and selects the master clock rate. It also enables automatic driving of the slave-select line.

In master mode the engine builds the serial clock from the system clock and shifts a byte out while it shifts another byte in. It can also pull the slave-select line low for the length of the byte. In slave mode it follows an external serial clock and slave-select, both taken into the system clock domain through two-flop synchronisers. The byte to send is loaded beforehand with the start strobe.

After each byte the engine raises a done pulse for one system clock and presents the received byte.

Top module: `spi_xfer_engine`

## Requirements
- R1: Control word layout: bit 7 auto slave-select enable, bit 6 engine enable, bit 5 LSB-first, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate code. The word is written when `cfgWr` is high and is 0 after reset.
- R2: In master mode the SCK half-period is 2^rate system clocks, so codes 0, 1, 2 and 3 give dividers of 2, 4, 8 and 16.
- R3: SCK rests at the polarity level between bytes. The first edge of a byte drives SCK to the opposite level.
- R4: With phase 0, the first data bit is on the output before the first SCK edge. Input is sampled on each leading edge, and the output moves on trailing edges.
- R5: With phase 1, the output moves on leading edges and input is sampled on trailing edges.
- R6: With LSB-first 0, data bit 7 goes first and the first received bit lands in bit 7. With LSB-first 1, bit 0 goes first and the first received bit lands in bit 0.
- R7: After 16 SCK edges, `rxDone` is high for exactly one clock with `rxByte` holding the received byte. In master mode SCK is back at its rest level by then.
- R8: `ssOe` is 1 only when enabled, in master mode, with auto slave-select set and `modeFaultDis` at 1. `ssO` is 0 during a byte and 1 between bytes.
- R9: With enable at 0, `txStart` has no effect. All output enables stay 0 and no `rxDone` is raised.
- R10: In slave mode, bits shift only while the synchronised SS is low. MISO is driven (`misoOe` = 1) only then. The byte sent is the one loaded by the last `txStart`.
- R11: In slave mode, SS going high in mid-byte drops the partial byte with no `rxDone`. The next byte starts again from its first bit.
- R12: In slave mode the rate code has no effect. The engine follows an external SCK whatever the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Write strobe for the control word |
| cfgData | input | 8 | Control word value |
| modeFaultDis | input | 1 | Mode-fault disable; needed for auto slave-select |
| txByte | input | 8 | Byte to transmit |
| txStart | input | 1 | Starts a master byte, or loads the slave transmit byte |
| rxByte | output | 8 | Last received byte |
| rxDone | output | 1 | One-clock pulse at the end of a byte |
| sckI | input | 1 | Serial clock from the pin (slave) |
| sckO | output | 1 | Serial clock to the pin (master) |
| sckOe | output | 1 | SCK output enable |
| mosiI | input | 1 | MOSI from the pin (slave) |
| mosiO | output | 1 | MOSI to the pin (master) |
| mosiOe | output | 1 | MOSI output enable |
| misoI | input | 1 | MISO from the pin (master) |
| misoO | output | 1 | MISO to the pin (slave) |
| misoOe | output | 1 | MISO output enable |
| ssI | input | 1 | Slave select from the pin (slave) |
| ssO | output | 1 | Slave select to the pin (master) |
| ssOe | output | 1 | Slave select output enable |

## Verification
The bench drives all four polarity/phase pairs in both roles and both bit orders. It acts as the peer device, so a design that samples on the wrong edge or moves data on the wrong edge gets a shifted or rotated byte in one direction.

It times the gap between master SCK edges for each rate code. A divider off by one shows up as the wrong gap.

It drops SS in mid-byte in slave mode. A design that keeps its bit count would frame the next byte wrongly or raise a false done pulse.

It also checks that auto slave-select stays undriven when mode-fault disable is low, and that a disabled engine ignores start.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  localparam int CFG_W  = 8;
  localparam int RATE_W = 2;

  // Control word; the first member sits in the top bit.
  typedef struct packed {
    logic              ssAuto;
    logic              enable;
    logic              lsbFirst;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrlWord_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL
  } xferState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
    logic rxBit;
  } dpStb_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 txStart,
  input  logic                 sckI,
  input  logic                 ssI,
  input  logic                 mosiI,
  input  logic                 misoI,
  output ctrlWord_t            cfg,
  output dpStb_t               stb,
  output logic                 sckLine,
  output logic                 ssLine,
  output logic                 ssSync
);

  localparam int HALF_W = (1 << RATE_W) - 1;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  ctrlWord_t          cfgReg;
  xferState_t         state;
  logic [HALF_W-1:0]  hcnt;
  logic [HALF_W-1:0]  halfLoad;
  logic [EDGE_W-1:0]  edgeCnt;
  logic               sckReg;
  logic               ssReg;
  logic [1:0]         sckSyn;
  logic [1:0]         ssSyn;
  logic [1:0]         mosiSyn;
  logic               sckPrev;
  logic               sckS;
  logic               mosiS;
  logic               mEdge;
  logic               sEdge;
  logic               edgeEv;
  logic               leading;
  logic               lastEdge;

  // Control word register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWr) cfgReg <= ctrlWord_t'(cfgData);
  end
  assign cfg = cfgReg;

  // Two-flop synchronisers for the slave pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSyn  <= '0;
      ssSyn   <= '1;
      mosiSyn <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSyn  <= {sckSyn[0], sckI};
      ssSyn   <= {ssSyn[0], ssI};
      mosiSyn <= {mosiSyn[0], mosiI};
      sckPrev <= sckSyn[1];
    end
  end
  assign sckS   = sckSyn[1];
  assign ssSync = ssSyn[1];
  assign mosiS  = mosiSyn[1];

  always_comb halfLoad = HALF_W'((1 << cfgReg.rate) - 1);

  assign mEdge    = (state == ST_RUN) && cfgReg.master && (hcnt == '0);
  assign sEdge    = (state == ST_RUN) && !cfgReg.master && (sckS != sckPrev);
  assign edgeEv   = mEdge || sEdge;
  assign leading  = ~edgeCnt[0];
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));

  always_comb begin
    stb.load   = cfgReg.enable && txStart && (state == ST_IDLE);
    stb.sample = edgeEv && (cfgReg.cpha ? !leading : leading);
    stb.shift  = edgeEv && (cfgReg.cpha ? (leading && (edgeCnt != '0))
                                        : (!leading && !lastEdge));
    stb.finish = (state == ST_TAIL) && (hcnt == '0);
    stb.rxBit  = cfgReg.master ? misoI : mosiS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      edgeCnt <= '0;
      sckReg  <= 1'b0;
      ssReg   <= 1'b1;
    end else if (!cfgReg.enable) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      edgeCnt <= '0;
      sckReg  <= cfgReg.cpol;
      ssReg   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sckReg  <= cfgReg.cpol;
          edgeCnt <= '0;
          hcnt    <= halfLoad;
          ssReg   <= 1'b1;
          if (cfgReg.master && txStart) begin
            state <= ST_RUN;
            ssReg <= 1'b0;
          end else if (!cfgReg.master && !ssSync) begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!cfgReg.master && ssSync) begin
            state   <= ST_IDLE;
            edgeCnt <= '0;
          end else if (edgeEv) begin
            edgeCnt <= edgeCnt + 1'b1;
            if (cfgReg.master) begin
              sckReg <= ~sckReg;
              hcnt   <= halfLoad;
            end
            if (lastEdge) begin
              state <= ST_TAIL;
              hcnt  <= cfgReg.master ? halfLoad : '0;
            end
          end else if (cfgReg.master && (hcnt != '0)) begin
            hcnt <= hcnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (hcnt == '0) begin
            state <= ST_IDLE;
            ssReg <= 1'b1;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sckLine = sckReg;
  assign ssLine  = ssReg;

  // R9: disabling returns the sequencer to idle on the next clock
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg.enable |=> (state == ST_IDLE));

  // R8: the select line is high whenever no byte is in progress
  a_r8_ss_high_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> ssReg);

  // R11: SS rising during a slave byte abandons it
  a_r11_slave_abort: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReg.master && (state == ST_RUN) && ssSync) |=> (state == ST_IDLE));

endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lsbFirst,
  input  dpStb_t            stb,
  input  logic [DATA_W-1:0] txByte,
  output logic              txBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone
);

  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] rxReg;
  logic              doneReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr <= '0;
    end else if (stb.load) begin
      txSr <= txByte;
    end else if (stb.shift) begin
      txSr <= lsbFirst ? (txSr >> 1) : (txSr << 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr <= '0;
    end else if (stb.sample) begin
      rxSr <= lsbFirst ? {stb.rxBit, rxSr[DATA_W-1:1]}
                       : {rxSr[DATA_W-2:0], stb.rxBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= stb.finish;
      if (stb.finish) rxReg <= rxSr;
    end
  end

  assign txBit  = lsbFirst ? txSr[0] : txSr[DATA_W-1];
  assign rxByte = rxReg;
  assign rxDone = doneReg;

  // R7: the done flag never lasts longer than one clock
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R4: a load never coincides with shift or sample activity
  a_r4_load_excl: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (!stb.shift && !stb.sample));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              modeFaultDis,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txStart,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone,
  input  logic              sckI,
  output logic              sckO,
  output logic              sckOe,
  input  logic              mosiI,
  output logic              mosiO,
  output logic              mosiOe,
  input  logic              misoI,
  output logic              misoO,
  output logic              misoOe,
  input  logic              ssI,
  output logic              ssO,
  output logic              ssOe
);

  ctrlWord_t cfg;
  dpStb_t    stb;
  logic      sckLine;
  logic      ssLine;
  logic      ssSync;
  logic      txBit;

  spi_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .cfgData (cfgData),
    .txStart (txStart),
    .sckI    (sckI),
    .ssI     (ssI),
    .mosiI   (mosiI),
    .misoI   (misoI),
    .cfg     (cfg),
    .stb     (stb),
    .sckLine (sckLine),
    .ssLine  (ssLine),
    .ssSync  (ssSync)
  );

  spi_xfer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lsbFirst (cfg.lsbFirst),
    .stb      (stb),
    .txByte   (txByte),
    .txBit    (txBit),
    .rxByte   (rxByte),
    .rxDone   (rxDone)
  );

  assign sckO   = sckLine;
  assign sckOe  = cfg.enable && cfg.master;
  assign mosiO  = txBit;
  assign mosiOe = cfg.enable && cfg.master;
  assign misoO  = txBit;
  assign misoOe = cfg.enable && !cfg.master && !ssSync;
  assign ssO    = ssLine;
  assign ssOe   = cfg.enable && cfg.master && cfg.ssAuto && modeFaultDis;

  // R10: MOSI and MISO are never driven together
  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mosiOe, misoOe}));

  // R8: the select output is only driven when this side is master
  a_r8_ss_master_only: assert property (@(posedge clk) disable iff (!rstN)
    ssOe |-> sckOe);

endmodule

// File: tb/spi_xfer_engine_bench.sv
`timescale 1ns/1ps
module spi_xfer_engine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic       modeFaultDis = 1'b0;
  logic [7:0] txByte = '0;
  logic       txStart = 1'b0;
  logic [7:0] rxByte;
  logic       rxDone;
  logic       sckI = 1'b0;
  logic       sckO, sckOe;
  logic       mosiI = 1'b0;
  logic       mosiO, mosiOe;
  logic       misoI = 1'b0;
  logic       misoO, misoOe;
  logic       ssI = 1'b1;
  logic       ssO, ssOe;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_xfer_engine u_spi_xfer_engine (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .modeFaultDis(modeFaultDis), .txByte(txByte), .txStart(txStart),
    .rxByte(rxByte), .rxDone(rxDone),
    .sckI(sckI), .sckO(sckO), .sckOe(sckOe),
    .mosiI(mosiI), .mosiO(mosiO), .mosiOe(mosiOe),
    .misoI(misoI), .misoO(misoO), .misoOe(misoOe),
    .ssI(ssI), .ssO(ssO), .ssOe(ssOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  // R1: bit7 auto SS, bit6 enable, bit5 LSB-first, bit4 master, bit3 CPOL, bit2 CPHA, bits1:0 rate
  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWr = 1'b1; cfgData = v;
    @(negedge clk); cfgWr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    check(rxByte == 8'h00, "R1 reset rxByte", rxByte, 0);
    check(rxDone == 1'b0, "R7 reset rxDone", rxDone, 0);
    check({sckOe, mosiOe, misoOe, ssOe} == 4'b0, "R9 reset enables",
          {sckOe, mosiOe, misoOe, ssOe}, 0);
  endtask

  // Bench plays the slave; engine is master
  task automatic masterXfer(input logic [7:0] cfgv, input logic [7:0] mOut,
                            input logic [7:0] sIn, input string tag);
    logic cpol, cpha, lsb, prev, ssExp;
    logic [7:0] got;
    int rate;
    bit seen;
    cpha = cfgv[2]; cpol = cfgv[3]; lsb = cfgv[5]; rate = int'(cfgv[1:0]);
    ssExp = cfgv[7] & modeFaultDis;
    got = '0; seen = 0;
    writeCfg(cfgv);
    check(sckO == cpol, {tag, " R3 idle level"}, sckO, cpol);
    misoI = cpha ? 1'b0 : bitOf(sIn, 0, lsb);
    txByte = mOut;
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    if (!cpha) check(mosiO == bitOf(mOut, 0, lsb), {tag, " R4 first bit early"},
                     mosiO, bitOf(mOut, 0, lsb));
    prev = cpol;
    for (int e = 0; e < 16; e++) begin
      int cnt = 0;
      int k = e / 2;
      bit lead = (e % 2) == 0;
      while (sckO == prev && cnt < 200) begin @(negedge clk); cnt++; end
      prev = sckO;
      if (e == 0) check(sckO == !cpol, {tag, " R3 leading level"}, sckO, !cpol);
      if (e == 3) check(cnt == (1 << rate), {tag, " R2 half period"}, cnt, 1 << rate);
      if (e == 7) begin
        check(ssOe == ssExp, {tag, " R8 ssOe"}, ssOe, ssExp);
        check(ssO == 1'b0, {tag, " R8 ss low in byte"}, ssO, 0);
      end
      if (cpha ? !lead : lead) begin
        if (lsb) got[k] = mosiO; else got[7-k] = mosiO;
      end
      if (cpha ? lead : (!lead && k < 7))
        misoI = bitOf(sIn, cpha ? k : k + 1, lsb);
    end
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (rxDone) seen = 1;
    end
    check(seen, {tag, " R7 done raised"}, seen, 1);
    check(rxByte == sIn, {tag, cpha ? " R5 R6 rx byte" : " R4 R6 rx byte"}, rxByte, sIn);
    check(got == mOut, {tag, cpha ? " R5 R6 tx byte" : " R4 R6 tx byte"}, got, mOut);
    check(sckO == cpol, {tag, " R7 sck rest"}, sckO, cpol);
    @(negedge clk);
    check(rxDone == 1'b0, {tag, " R7 done one clock"}, rxDone, 0);
    check(ssO == 1'b1, {tag, " R8 ss high after"}, ssO, 1);
  endtask

  // Bench plays the master; engine is slave
  task automatic slaveXfer(input logic [7:0] cfgv, input logic [7:0] sOut,
                           input logic [7:0] mIn, input int half, input string tag);
    logic cpol, cpha, lsb;
    logic [7:0] got;
    bit seen;
    cpha = cfgv[2]; cpol = cfgv[3]; lsb = cfgv[5];
    got = '0; seen = 0;
    ssI = 1'b1; sckI = cpol;
    writeCfg(cfgv);
    txByte = sOut;
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    repeat (4) @(negedge clk);
    check(misoOe == 1'b0, {tag, " R10 miso off while ss high"}, misoOe, 0);
    ssI = 1'b0;
    mosiI = cpha ? 1'b0 : bitOf(mIn, 0, lsb);
    repeat (4) @(negedge clk);
    check(misoOe == 1'b1, {tag, " R10 miso on while ss low"}, misoOe, 1);
    for (int k = 0; k < 8; k++) begin
      if (!cpha) begin
        repeat (half) @(negedge clk);
        if (lsb) got[k] = misoO; else got[7-k] = misoO;
        sckI = !cpol;
        repeat (half) @(negedge clk);
        sckI = cpol;
        if (k < 7) mosiI = bitOf(mIn, k + 1, lsb);
      end else begin
        sckI = !cpol;
        mosiI = bitOf(mIn, k, lsb);
        repeat (half) @(negedge clk);
        if (lsb) got[k] = misoO; else got[7-k] = misoO;
        sckI = cpol;
        if (k < 7) repeat (half) @(negedge clk);
      end
    end
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (rxDone) seen = 1;
    end
    check(seen, {tag, " R7 slave done raised"}, seen, 1);
    check(rxByte == mIn, {tag, " R10 R6 slave rx byte"}, rxByte, mIn);
    check(got == sOut, {tag, " R10 R6 slave tx byte"}, got, sOut);
    @(negedge clk);
    check(rxDone == 1'b0, {tag, " R7 slave done one clock"}, rxDone, 0);
    ssI = 1'b1;
    repeat (4) @(negedge clk);
    check(misoOe == 1'b0, {tag, " R10 miso released"}, misoOe, 0);
  endtask

  task automatic slaveAbort();
    bit seen = 0;
    ssI = 1'b1; sckI = 1'b0;
    writeCfg(8'h40);
    txByte = 8'hFF;
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    ssI = 1'b0; mosiI = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      repeat (4) @(negedge clk); sckI = 1'b1;
      repeat (4) @(negedge clk); sckI = 1'b0;
    end
    ssI = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rxDone) seen = 1;
    end
    check(!seen, "R11 no done after abort", seen, 0);
  endtask

  task automatic disabledStart();
    bit active = 0;
    modeFaultDis = 1'b1;
    writeCfg(8'h90);
    txByte = 8'h5A;
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sckOe || mosiOe || misoOe || ssOe || rxDone) active = 1;
    end
    check(!active, "R9 disabled engine idle", active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    disabledStart();
    modeFaultDis = 1'b1;
    masterXfer(8'h50, 8'hA5, 8'h3C, "M mode0 msb R1");
    masterXfer(8'h5D, 8'h96, 8'hE1, "M mode3 div4");
    masterXfer(8'h72, 8'h81, 8'h4B, "M lsb div8");
    masterXfer(8'hD7, 8'h1E, 8'hC3, "M autoSS div16");
    modeFaultDis = 1'b0;
    masterXfer(8'hD8, 8'h6C, 8'h35, "M autoSS blocked");
    slaveXfer(8'h40, 8'hB4, 8'h2D, 4, "S mode0");
    slaveXfer(8'h6F, 8'h71, 8'hD2, 4, "S lsb mode3 R12");
    slaveAbort();
    slaveXfer(8'h44, 8'h5E, 8'hA7, 4, "S after abort R11");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule